// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block produces the status a NOR-style flash device shows while its internal program or erase sequencer runs. A command decoder elsewhere sends a one-cycle `cmdDone` pulse when the last write of a command lands. The pulse carries the operation kind and a flag that says whether the target is protected. From the clock edge that samples the pulse, the block reports the device as busy. It does this in two ways. First, it enables a pull-down on the shared ready/busy line. Second, on every read it replaces the array data with a status word in which bit 6 inverts at the start of each new read.

A protected target gets no real work. Instead there is a fixed guard window, short for a program and long for an erase, after which reads return array data again. A running erase can be suspended. While it is suspended, ready/busy is released and reads see the array. A program may be issued during the suspension, and it shows busy status until it finishes, then falls back to the suspended state. A resume request continues the erase from where it stopped. Operation lengths are cycle-count parameters. The guard windows are derived from a clock-frequency parameter in MHz and a duration in microseconds.

Top module: `flash_status_resp`

## Requirements
- R1: While `rstN` is low and after its release, the pull-down enable is 0, the toggle state is 0, and no operation is in progress.
- R2: `dataOut` equals `arrayData` when `ceN` and `oeN` are both low and no operation is active, and equals 0 whenever either enable is high.
- R3: `opKind` 2'b01 means program and 2'b10 means erase; a `cmdDone` pulse with any other code has no effect. A valid command takes effect at the clock edge that samples `cmdDone`, so status shows from the following cycle.
- R4: An unprotected program keeps the block busy for exactly PROG_CYCLES cycles, then reads return array data.
- R5: An unprotected erase with no suspension keeps the block busy for exactly ERASE_CYCLES cycles.
- R6: `rdyBusyDrvLow` is 1 exactly while an operation is active (program, erase, guard window, or a program during suspension). It is 0 when idle and while an erase is suspended.
- R7: While an operation is active, a read shows a word that is 0 except at bit 6, which holds the toggle state. The toggle state inverts once at each read start, where a read start is the cycle both enables first become low, whichever enable framed it. It holds while no read starts and never changes when no operation is active.
- R8: A program to a protected target makes the block busy and toggling for CLK_MHZ*PROT_PROG_US cycles. A protected erase does the same for CLK_MHZ*PROT_ERASE_US cycles. After the window, reads return array data.
- R9: `suspReq` during a running erase with cycles still left releases busy and stops toggling from the next cycle. `resumeReq` then continues the erase, so one suspension adds exactly one cycle to the erase's total busy time.
- R10: A program issued while an erase is suspended is busy for PROG_CYCLES cycles, or for the protected guard window. It then returns to the suspended state, not to idle.
- R11: `cmdDone` while an operation is active, `suspReq` outside a running erase, `resumeReq` outside a suspension, and an erase command during a suspension are all ignored.
- R12: Coincident events follow fixed precedence. Completion wins over `suspReq` in the last erase cycle. A program command wins over `resumeReq` in the same cycle. A read start inverts the toggle state only if an operation is active in the cycle before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| cmdDone | input | 1 | One-cycle pulse: final command write completed |
| opKind | input | 2 | Operation code (01 program, 10 erase) |
| targetProt | input | 1 | Addressed target is protected |
| suspReq | input | 1 | Erase suspend request |
| resumeReq | input | 1 | Erase resume request |
| arrayData | input | DATA_W | Array word for the current address |
| dataOut | output | DATA_W | Read data or status word |
| rdyBusyDrvLow | output | 1 | Enable for the open-drain pull-down of the ready/busy line |

## Verification
A read start and a change of operation state can share one clock edge. The toggle decision at that edge must follow the state before the edge. The bench runs each operation several times with read pulses at shifted phases and periods, so that read starts land on the last busy cycle and on the first idle cycle. It predicts each inversion from its own cycle index, and it compares the status word or array word and the ready/busy line in every cycle. Control events that coincide are also forced together: `suspReq` in the final erase cycle, and a program command together with `resumeReq` during a suspension. These are judged by the busy lengths that follow them.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

  typedef enum logic [2:0] {
    ST_ARRAY = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_GUARD = 3'd3,
    ST_SUSP  = 3'd4,
    ST_SPROG = 3'd5
  } fsrState_t;

  typedef struct packed {
    logic statusMode;
    logic pullLow;
  } fsrStrobe_t;

  localparam logic [1:0] OP_PROGRAM = 2'b01;
  localparam logic [1:0] OP_ERASE   = 2'b10;

endpackage

// File: rtl/fsr_ctrl.sv
`timescale 1ns/1ps
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int PROG_CYCLES     = 2000,
  parameter int ERASE_CYCLES    = 50000,
  parameter int GUARD_PROG_CYC  = 250,
  parameter int GUARD_ERASE_CYC = 100000,
  parameter int CNT_W           = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdDone,
  input  logic [1:0] opKind,
  input  logic       targetProt,
  input  logic       suspReq,
  input  logic       resumeReq,
  output fsrStrobe_t strobe
);

  localparam logic [CNT_W-1:0] PROG_LOAD   = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD  = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GPROG_LOAD  = CNT_W'(GUARD_PROG_CYC - 1);
  localparam logic [CNT_W-1:0] GERASE_LOAD = CNT_W'(GUARD_ERASE_CYC - 1);

  fsrState_t        st, stNext;
  logic [CNT_W-1:0] mainCnt, mainNext;
  logic [CNT_W-1:0] subCnt, subNext;
  logic             isProg, isErase;

  assign isProg  = (opKind == OP_PROGRAM);
  assign isErase = (opKind == OP_ERASE);

  always_comb begin
    stNext   = st;
    mainNext = mainCnt;
    subNext  = subCnt;
    unique case (st)
      ST_ARRAY: begin
        if (cmdDone && isProg) begin
          stNext   = targetProt ? ST_GUARD : ST_PROG;
          mainNext = targetProt ? GPROG_LOAD : PROG_LOAD;
        end else if (cmdDone && isErase) begin
          stNext   = targetProt ? ST_GUARD : ST_ERASE;
          mainNext = targetProt ? GERASE_LOAD : ERASE_LOAD;
        end
      end
      ST_PROG, ST_GUARD: begin
        if (mainCnt == '0) stNext = ST_ARRAY;
        else               mainNext = mainCnt - 1'b1;
      end
      ST_ERASE: begin
        if (mainCnt == '0)  stNext = ST_ARRAY;
        else if (suspReq)   stNext = ST_SUSP;
        else                mainNext = mainCnt - 1'b1;
      end
      ST_SUSP: begin
        if (cmdDone && isProg) begin
          stNext  = ST_SPROG;
          subNext = targetProt ? GPROG_LOAD : PROG_LOAD;
        end else if (resumeReq) begin
          stNext = ST_ERASE;
        end
      end
      ST_SPROG: begin
        if (subCnt == '0) stNext = ST_SUSP;
        else              subNext = subCnt - 1'b1;
      end
      default: stNext = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_ARRAY;
      mainCnt <= '0;
      subCnt  <= '0;
    end else begin
      st      <= stNext;
      mainCnt <= mainNext;
      subCnt  <= subNext;
    end
  end

  logic activeSt;
  assign activeSt = (st == ST_PROG) || (st == ST_ERASE) ||
                    (st == ST_GUARD) || (st == ST_SPROG);

  always_comb begin
    strobe.statusMode = activeSt;
    strobe.pullLow    = activeSt;
  end

  assert_cmd_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ARRAY && cmdDone && (isProg || isErase)) |=> strobe.pullLow);

  assert_suspend_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ERASE && suspReq && mainCnt != '0) |=> (!strobe.pullLow && !strobe.statusMode));

  assert_progress_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SUSP || st == ST_SPROG) |=> $stable(mainCnt));

  assert_no_spurious_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pullLow && !cmdDone && !resumeReq) |=> !strobe.pullLow);

  assert_sprog_returns_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SPROG && subCnt == '0) |=> (st == ST_SUSP));

endmodule

// File: rtl/fsr_data.sv
`timescale 1ns/1ps
module fsr_data
  import fsr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] arrayData,
  input  fsrStrobe_t        strobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              rdyBusyDrvLow
);

  logic rdNow, rdPrev, readBegin, toggleQ;
  logic [DATA_W-1:0] statusWord;

  assign rdNow     = ~ceN & ~oeN;
  assign readBegin = rdNow & ~rdPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      rdPrev <= rdNow;
      if (readBegin && strobe.statusMode) toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    statusWord             = '0;
    statusWord[TOGGLE_BIT] = toggleQ;
    if (!rdNow)                 dataOut = '0;
    else if (strobe.statusMode) dataOut = statusWord;
    else                        dataOut = arrayData;
  end

  assign rdyBusyDrvLow = strobe.pullLow;

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.statusMode |=> $stable(toggleQ));

  assert_noread_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdNow |=> $stable(toggleQ));

  assert_flip_on_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusMode && readBegin) |=> (toggleQ != $past(toggleQ)));

endmodule

// File: rtl/flash_status_resp.sv
`timescale 1ns/1ps
module flash_status_resp
  import fsr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int TOGGLE_BIT    = 6,
  parameter int CLK_MHZ       = 250,
  parameter int PROT_PROG_US  = 1,
  parameter int PROT_ERASE_US = 400,
  parameter int PROG_CYCLES   = 2000,
  parameter int ERASE_CYCLES  = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              cmdDone,
  input  logic [1:0]        opKind,
  input  logic              targetProt,
  input  logic              suspReq,
  input  logic              resumeReq,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              rdyBusyDrvLow
);

  localparam int GUARD_PROG_CYC  = CLK_MHZ * PROT_PROG_US;
  localparam int GUARD_ERASE_CYC = CLK_MHZ * PROT_ERASE_US;
  localparam int MAX_A  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_B  = (GUARD_PROG_CYC > GUARD_ERASE_CYC) ? GUARD_PROG_CYC : GUARD_ERASE_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  fsrStrobe_t strobe;

  fsr_ctrl #(
    .PROG_CYCLES    (PROG_CYCLES),
    .ERASE_CYCLES   (ERASE_CYCLES),
    .GUARD_PROG_CYC (GUARD_PROG_CYC),
    .GUARD_ERASE_CYC(GUARD_ERASE_CYC),
    .CNT_W          (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdDone   (cmdDone),
    .opKind    (opKind),
    .targetProt(targetProt),
    .suspReq   (suspReq),
    .resumeReq (resumeReq),
    .strobe    (strobe)
  );

  fsr_data #(
    .DATA_W    (DATA_W),
    .TOGGLE_BIT(TOGGLE_BIT)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .ceN          (ceN),
    .oeN          (oeN),
    .arrayData    (arrayData),
    .strobe       (strobe),
    .dataOut      (dataOut),
    .rdyBusyDrvLow(rdyBusyDrvLow)
  );

endmodule

// File: tb/flash_status_resp_test.sv
`timescale 1ns/1ps
module flash_status_resp_test;

  localparam int CLK_MHZ = 4;
  localparam int PP_US   = 2;
  localparam int PE_US   = 10;
  localparam int PROG_N  = 12;
  localparam int ERASE_N = 30;
  localparam int GP_N    = CLK_MHZ * PP_US;
  localparam int GE_N    = CLK_MHZ * PE_US;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, cmdDone, targetProt, suspReq, resumeReq;
  logic [1:0]  opKind;
  logic [15:0] arrayData, dataOut;
  logic        rdyBusyDrvLow;
  wire         rbLine = ~rdyBusyDrvLow;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  bit  expTog = 1'b0;
  bit  prevDrv = 1'b0;
  int  seq = 0;

  always #2 clk = ~clk;

  flash_status_resp #(
    .DATA_W(16), .TOGGLE_BIT(6), .CLK_MHZ(CLK_MHZ),
    .PROT_PROG_US(PP_US), .PROT_ERASE_US(PE_US),
    .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .cmdDone(cmdDone),
    .opKind(opKind), .targetProt(targetProt), .suspReq(suspReq),
    .resumeReq(resumeReq), .arrayData(arrayData), .dataOut(dataOut),
    .rdyBusyDrvLow(rdyBusyDrvLow)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic pulse(input bit cmd, input logic [1:0] kind, input bit prot,
                       input bit sp, input bit rs);
    ceN = 1'b1; oeN = 1'b1;
    cmdDone = cmd; opKind = kind; targetProt = prot;
    suspReq = sp; resumeReq = rs;
    step();
    cmdDone = 1'b0; opKind = 2'b00; targetProt = 1'b0;
    suspReq = 1'b0; resumeReq = 1'b0;
    prevDrv = 1'b0;
  endtask

  // Sample i is the i-th cycle after the edge that started the phase;
  // an operation is active at sample i exactly when i < len.
  task automatic runPart(input int len, input int count, input bit useCe,
                         input int phase, input int period, input int inj,
                         input string tag);
    for (int i = 0; i < count; i++) begin
      bit act = (i < len);
      bit nRd;
      chk(rbLine == !act, tag, "R6 ready/busy line", 32'(rbLine), 32'(!act));
      if (prevDrv) begin
        if (act)
          chk(dataOut == (16'(expTog) << 6), tag, "R7 status word",
              32'(dataOut), 32'(16'(expTog) << 6));
        else
          chk(dataOut == arrayData, tag, "R2 array read", 32'(dataOut), 32'(arrayData));
      end
      cmdDone = 1'b0; suspReq = 1'b0; resumeReq = 1'b0; opKind = 2'b00;
      if (i == inj) begin
        cmdDone = 1'b1; opKind = 2'b10; suspReq = 1'b1; resumeReq = 1'b1;
      end
      nRd = (((i + phase) % period) == 0);
      if (!nRd) begin
        if (useCe) begin ceN = 1'b1; oeN = 1'b0; end
        else       begin ceN = 1'b0; oeN = 1'b1; end
      end else begin
        ceN = 1'b0; oeN = 1'b0;
      end
      seq++;
      arrayData = 16'h3C5A ^ 16'(seq * 16'h0F1D);
      if (nRd && !prevDrv && act) expTog = ~expTog;
      prevDrv = nRd;
      step();
    end
    cmdDone = 1'b0; suspReq = 1'b0; resumeReq = 1'b0; opKind = 2'b00;
  endtask

  task automatic runOp(input int len, input bit useCe, input int phase,
                       input int period, input int inj, input string tag);
    runPart(len, len + 3, useCe, phase, period, inj, tag);
    ceN = 1'b1; oeN = 1'b1;
    step();
    prevDrv = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; cmdDone = 1'b0; opKind = 2'b00;
    targetProt = 1'b0; suspReq = 1'b0; resumeReq = 1'b0; arrayData = 16'h1234;
    step(); step(); step();
    chk(rdyBusyDrvLow == 1'b0, "R1", "pull-down in reset", 32'(rdyBusyDrvLow), 0);
    chk(dataOut == 16'h0, "R1", "output in reset", 32'(dataOut), 0);
    rstN = 1'b1;
    step();
    chk(rdyBusyDrvLow == 1'b0, "R1", "pull-down after reset", 32'(rdyBusyDrvLow), 0);

    // R2: idle reads under both framings, and disabled output
    runPart(0, 8, 1'b0, 0, 2, -1, "R2");
    runPart(0, 8, 1'b1, 1, 3, -1, "R2");
    ceN = 1'b1; oeN = 1'b0; #0.1;
    chk(dataOut == 16'h0, "R2", "ce high gives zero", 32'(dataOut), 0);
    ceN = 1'b0; oeN = 1'b1; #0.1;
    chk(dataOut == 16'h0, "R2", "oe high gives zero", 32'(dataOut), 0);

    // R3: undefined operation codes do nothing
    pulse(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    runPart(0, 4, 1'b0, 0, 2, -1, "R3");
    pulse(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
    runPart(0, 4, 1'b0, 0, 2, -1, "R3");

    // R4/R7: program at several read phases and periods
    for (int ph = 0; ph < 3; ph++) begin
      pulse(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
      runOp(PROG_N, ph[0], ph, 2 + ph, -1, "R4");
    end
    // R7: sparse reads, toggle holds across gaps
    pulse(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
    runOp(PROG_N, 1'b0, 1, 5, -1, "R7");

    // R5: erase under chip-enable framing, then output-enable framing
    pulse(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    runOp(ERASE_N, 1'b1, 0, 2, -1, "R5");
    pulse(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    runOp(ERASE_N, 1'b0, 1, 2, -1, "R5");

    // R8: protected windows
    pulse(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
    runOp(GP_N, 1'b0, 0, 2, -1, "R8");
    pulse(1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
    runOp(GE_N, 1'b1, 1, 3, -1, "R8");

    // R11: commands, suspend and resume during a program are ignored
    pulse(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
    runOp(PROG_N, 1'b0, 0, 2, 4, "R11");
    // R11: suspend during a protected erase window is ignored
    pulse(1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
    runOp(GE_N, 1'b0, 1, 2, 7, "R11");

    // R9/R10: suspend, programs during suspension, resume
    pulse(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    runPart(ERASE_N, 10, 1'b0, 0, 2, -1, "R9");
    pulse(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    runPart(0, 6, 1'b0, 0, 2, -1, "R9");
    pulse(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    runPart(0, 4, 1'b0, 1, 2, -1, "R11");
    pulse(1'b1, 2'b01, 1'b0, 1'b0, 1'b1);
    runOp(PROG_N, 1'b1, 0, 2, 3, "R12");
    pulse(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
    runOp(GP_N, 1'b0, 1, 2, -1, "R10");
    pulse(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    runOp(ERASE_N - 10, 1'b0, 0, 2, -1, "R9");

    // R12: suspend in the final erase cycle loses to completion
    pulse(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
    runPart(ERASE_N, ERASE_N - 1, 1'b0, 0, 2, -1, "R12");
    pulse(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    runPart(0, 4, 1'b0, 0, 2, -1, "R12");
    pulse(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
    runPart(0, 4, 1'b0, 1, 2, -1, "R11");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule